// File: doc/BRIEF.md
# Quad I/O Flash Read Sequencer

This block is the host side of a four-line serial flash read path. A client hands it a 16-byte-aligned start address, a byte count and a flag that says whether the flash should stay in command-less continuous mode afterwards. The sequencer lowers chip select, sends the read opcode on one line when the flash still expects it, sends the address and a mode byte on all four lines, releases the bus, and shifts data back two nibbles per byte. Because the start address is aligned, no dummy clocks are needed between the mode byte and the first data nibble.

The block remembers across transactions whether the last mode byte asked the flash to stay in continuous mode. If it did, the next access starts directly with the address and saves eight serial clocks. A separate request kind sends a run of all-ones clocks on every line, which drops the flash out of continuous mode; the tracked flag is cleared with it. Received bytes leave on a valid/ready stream with a one-byte holding register. When the consumer stalls, the serial clock stops between bytes rather than losing data.

Top module: `qio_flash_reader`

## Requirements
- R1: Between transactions chip select `cs_n` is high, `sclk` is low and all four `io_oe` bits are low (SPI mode 0 idle); this is also the state after reset.
- R2: When the flash is not in continuous mode, a read begins with 8 clocks carrying opcode E3h on IO0, most significant bit first, with `io_oe` = 0001b.
- R3: The 24-bit address follows in 6 clocks on IO3..IO0, most significant nibble first (IO3 carrying the highest bit of the nibble), then the 8-bit mode byte in 2 clocks, high nibble first, with `io_oe` = 1111b; the mode byte is 20h when `req_keep` is 1 and 00h otherwise, and no dummy clocks follow.
- R4: Data is sampled on rising `sclk` edges, high nibble first, and the bytes appear on `out_data` in ascending address order; a read of N bytes holds chip select low for exactly H+8+2N clocks, with H = 8 or 0.
- R5: After a read whose mode byte was 20h, the next read omits the opcode (H = 0); after a read with mode 00h, the next read includes it (H = 8).
- R6: From the falling edge that ends the second mode clock until chip select rises, all `io_oe` bits are low.
- R7: A read request whose address has a nonzero low nibble, whose `req_len` is 0, or that arrives while `cfg_quad_en` is low is rejected: `req_err` is high for one cycle after acceptance and chip select stays high.
- R8: A request with `req_mreset` = 1 drives MRST_CLKS (default 16) clocks with `io_out` = 1111b and `io_oe` = 1111b and clears the continuous flag, so the next read includes the opcode.
- R9: While `out_valid` is high and `out_ready` low, `out_data` and `out_valid` hold; the serial clock waits low before the next byte instead of overwriting it, so no byte is lost or duplicated.
- R10: Chip select stays high for at least CS_GAP cycles between transactions, and `req_ready` is high only when the sequencer is idle and its output register is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_quad_en | input | 1 | High when the flash has four-line mode enabled |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 24 | Start address, low nibble must be zero |
| req_len | input | LEN_W | Number of bytes to read, nonzero |
| req_keep | input | 1 | Leave the flash in continuous mode after this read |
| req_mreset | input | 1 | Issue the continuous-mode exit sequence instead of a read |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Received byte |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Values driven onto IO3..IO0 |
| io_oe | output | 4 | Output enables for IO3..IO0 |
| io_in | input | 4 | Values sampled from IO3..IO0 |

## Verification
Reads are issued from the normal state, after a keep request, and after a non-keep request from continuous mode, so the bench distinguishes a sequencer that always sends the opcode, never sends it, or updates its flag a transaction late. A behavioural flash model decodes the pins, tracks its own continuous state from the received mode bits and returns an address-derived pattern, which separates nibble-order, address-shift and off-by-one byte-count faults. Misaligned, zero-length and quad-disabled requests check that rejection leaves the bus untouched, and the exit sequence is followed by a read to prove the flag was cleared. A random ready pattern with long bursts, including one that wraps the top of the address space, exposes overwritten or repeated bytes.

// File: rtl/qfr_pkg.sv
// Shared types and constants for the quad flash read sequencer.
// Assumes a flash that decodes the opcode serially on IO0 and the
// address/mode fields on all four lines.
package qfr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DATA,
        PH_GAP,
        PH_MRST
    } phase_e;

    localparam logic [7:0] RD_OPCODE = 8'hE3;
    localparam logic [7:0] MODE_STAY = 8'h20;
    localparam logic [7:0] MODE_EXIT = 8'h00;

    localparam int CMD_CLKS  = 8;
    localparam int ADDR_CLKS = 6;
    localparam int MODE_CLKS = 2;

endpackage

// File: rtl/qfr_tick_gen.sv
// Divided enable for the serial clock: one pulse every DIV system
// cycles while run is high, each pulse marking one half period of sclk.
// Assumes DIV >= 1; the count restarts whenever run drops.
module qfr_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(DIV + 1);

    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == W'(DIV - 1));

    // Count system cycles within one half period of sclk.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == W'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/qfr_pin_mux.sv
// Selects what the host drives on the four data lines for the current
// phase and clock index. Purely combinational; assumes cnt is the index
// of the serial clock within the phase and stays in range for it.
module qfr_pin_mux
    import qfr_pkg::*;
(
    input  phase_e      phase,
    input  logic [2:0]  cnt,
    input  logic [23:0] addr,
    input  logic [7:0]  mode,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe
);
    logic [4:0] nib_lsb;

    assign nib_lsb = 5'd20 - {cnt, 2'b00};

    // Map phase and clock index onto line values and enables.
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        case (phase)
            PH_CMD: begin
                io_oe  = 4'b0001;
                io_out = {3'b000, RD_OPCODE[3'd7 - cnt]};
            end
            PH_ADDR: begin
                io_oe  = 4'b1111;
                io_out = addr[nib_lsb +: 4];
            end
            PH_MODE: begin
                io_oe  = 4'b1111;
                io_out = cnt[0] ? mode[3:0] : mode[7:4];
            end
            PH_MRST: begin
                io_oe  = 4'b1111;
                io_out = 4'b1111;
            end
            default: begin
                io_out = 4'b0000;
                io_oe  = 4'b0000;
            end
        endcase
    end
endmodule

// File: rtl/qfr_byte_asm.sv
// Joins two received nibbles into a byte and holds it in a one-entry
// output register with valid/ready handshake. Assumes the caller never
// strobes cap_lo while a byte is still waiting.
module qfr_byte_asm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_hi,
    input  logic       cap_lo,
    input  logic [3:0] nib_in,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data
);
    logic [3:0] hi_q;
    logic [7:0] data_q;
    logic       valid_q;

    assign out_valid = valid_q;
    assign out_data  = data_q;

    // Store nibbles and manage the output holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= 4'h0;
            data_q  <= 8'h00;
            valid_q <= 1'b0;
        end else begin
            if (cap_hi) begin
                hi_q <= nib_in;
            end
            if (cap_lo) begin
                data_q  <= {hi_q, nib_in};
                valid_q <= 1'b1;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    // A completed byte must never land on an unread one.
    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_lo |-> !valid_q);

    // A waiting byte stays put until the consumer takes it.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !out_ready) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/qio_flash_reader.sv
// Host-side sequencer for aligned four-line flash reads with continuous
// mode tracking and an exit sequence. Assumes the flash already has
// four-line mode enabled (signalled by cfg_quad_en), that io_in is
// stable around rising sclk edges, and CLK_DIV, CS_GAP >= 1.
module qio_flash_reader
    import qfr_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int LEN_W     = 8,
    parameter int CS_GAP    = 4,
    parameter int MRST_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_quad_en,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_keep,
    input  logic             req_mreset,
    output logic             req_err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             cs_n,
    output logic             sclk,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    localparam int MAXC  = (MRST_CLKS > CMD_CLKS) ? MRST_CLKS : CMD_CLKS;
    localparam int CNT_W = $clog2(MAXC);
    localparam int GAP_W = $clog2(CS_GAP + 1);

    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   left_q;
    logic [23:0]        addr_q;
    logic [7:0]         mode_q;
    logic               cont_q;
    logic               sclk_q;
    logic [GAP_W-1:0]   gap_q;
    logic               err_q;

    logic run, tick, stall, rise, fall;
    logic cap_hi, cap_lo, accept, bad_req, phase_end, byte_end;

    // Bus is owned while any serial phase is running.
    always_comb begin
        run = (phase_q != PH_IDLE) && (phase_q != PH_GAP);
    end

    // Clock edge requests, with the pause before a byte if output is full.
    always_comb begin
        stall    = (phase_q == PH_DATA) && (cnt_q == '0) && out_valid;
        rise     = tick && !sclk_q && !stall;
        fall     = tick && sclk_q;
        cap_hi   = rise && (phase_q == PH_DATA) && (cnt_q == '0);
        cap_lo   = rise && (phase_q == PH_DATA) && (cnt_q == CNT_W'(1));
        byte_end = (phase_q == PH_DATA) && (cnt_q == CNT_W'(1));
    end

    // Last clock of the current phase.
    always_comb begin
        case (phase_q)
            PH_CMD:  phase_end = (cnt_q == CNT_W'(CMD_CLKS - 1));
            PH_ADDR: phase_end = (cnt_q == CNT_W'(ADDR_CLKS - 1));
            PH_MODE: phase_end = (cnt_q == CNT_W'(MODE_CLKS - 1));
            PH_MRST: phase_end = (cnt_q == CNT_W'(MRST_CLKS - 1));
            PH_DATA: phase_end = byte_end && (left_q == '0);
            default: phase_end = 1'b0;
        endcase
    end

    // Request acceptance and validity screening.
    always_comb begin
        req_ready = (phase_q == PH_IDLE) && !out_valid;
        accept    = req_valid && req_ready;
        bad_req   = !req_mreset &&
                    ((req_addr[3:0] != 4'h0) || !cfg_quad_en || (req_len == '0));
    end

    qfr_tick_gen #(
        .DIV (CLK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    // Phase sequencing, serial clock, continuous flag and deselect timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
            addr_q  <= 24'h0;
            mode_q  <= MODE_EXIT;
            cont_q  <= 1'b0;
            sclk_q  <= 1'b0;
            gap_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        cnt_q <= '0;
                        if (req_mreset) begin
                            phase_q <= PH_MRST;
                            cont_q  <= 1'b0;
                        end else if (bad_req) begin
                            err_q <= 1'b1;
                        end else begin
                            addr_q  <= req_addr;
                            mode_q  <= req_keep ? MODE_STAY : MODE_EXIT;
                            left_q  <= req_len - 1'b1;
                            phase_q <= cont_q ? PH_ADDR : PH_CMD;
                            cont_q  <= req_keep;
                        end
                    end
                end
                PH_GAP: begin
                    if (gap_q == GAP_W'(CS_GAP - 1)) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: begin
                    if (rise) begin
                        sclk_q <= 1'b1;
                    end else if (fall) begin
                        sclk_q <= 1'b0;
                        if (phase_end) begin
                            cnt_q <= '0;
                            case (phase_q)
                                PH_CMD:  phase_q <= PH_ADDR;
                                PH_ADDR: phase_q <= PH_MODE;
                                PH_MODE: phase_q <= PH_DATA;
                                default: begin
                                    phase_q <= PH_GAP;
                                    gap_q   <= '0;
                                end
                            endcase
                        end else if (byte_end) begin
                            cnt_q  <= '0;
                            left_q <= left_q - 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    qfr_pin_mux u_pins (
        .phase  (phase_q),
        .cnt    (cnt_q[2:0]),
        .addr   (addr_q),
        .mode   (mode_q),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    qfr_byte_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_hi    (cap_hi),
        .cap_lo    (cap_lo),
        .nib_in    (io_in),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign cs_n    = !run;
    assign sclk    = sclk_q;
    assign req_err = err_q;

    // Mode 0: the serial clock rests low whenever chip select is high.
    assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // Host lines are released for the whole data phase.
    assert_bus_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |-> (io_oe == 4'b0000));

    // The exit sequence drives every line high.
    assert_exit_all_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MRST) |-> ((io_out == 4'b1111) && (io_oe == 4'b1111)));

    // A rejected request leaves the bus deselected.
    assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (cs_n && $past(phase_q == PH_IDLE)));

    // Chip select never bounces straight back low after rising.
    assert_deselect_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
endmodule

// File: tb/tb_qio_flash_reader.sv
`timescale 1ns/1ps
module tb_qio_flash_reader;
    localparam int CLK_DIV   = 2;
    localparam int LEN_W     = 8;
    localparam int CS_GAP    = 4;
    localparam int MRST_CLKS = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_quad_en = 1'b1;
    logic             req_valid = 1'b0;
    logic [23:0]      req_addr = 24'h0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_keep = 1'b0;
    logic             req_mreset = 1'b0;
    logic             req_ready, req_err, out_valid, out_ready;
    logic [7:0]       out_data;
    logic             cs_n, sclk;
    logic [3:0]       io_out, io_oe;
    logic [3:0]       io_in = 4'h0;
    logic             bp_mode = 1'b0;
    logic [7:0]       lfsr = 8'h5B;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 0;

    logic [7:0] exp_q[$];

    // flash model state
    int          k, hdr, gap, starts, d;
    bit          mcont, oe_bad, rst_ok, prev_sclk, seen, idle_bad;
    bit          prev_cs = 1'b1;
    bit          exp_rst;
    logic [7:0]  rx_cmd, rx_mode, nb;
    logic [23:0] rx_addr;
    int          exp_hdr, exp_len;
    logic [23:0] exp_addr;
    logic [7:0]  exp_mode;
    bit          tb_cont;

    // monitor state
    bit          pend;
    logic [7:0]  pend_data, e;

    always #4 clk = ~clk;

    qio_flash_reader #(
        .CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .CS_GAP(CS_GAP), .MRST_CLKS(MRST_CLKS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_quad_en(cfg_quad_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_keep(req_keep), .req_mreset(req_mreset),
        .req_err(req_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .cs_n(cs_n), .sclk(sclk), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in)
    );

    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign out_ready = !bp_mode || lfsr[0];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fmem(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
    endfunction

    // Behavioural flash: decodes pins mid-cycle, drives data after falling sclk.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sclk) idle_bad = 1'b1;
            if (!cs_n && prev_cs) begin
                if (seen) chk(gap >= CS_GAP, "R10 deselect gap", gap, CS_GAP);
                gap = 0; k = 0; rx_cmd = 0; rx_addr = 0; rx_mode = 0;
                oe_bad = 0; rst_ok = 1; hdr = mcont ? 0 : 8; starts++;
            end
            if (cs_n) gap++;
            if (!cs_n && sclk && !prev_sclk) begin
                if (exp_rst) begin
                    if (io_out != 4'hF || io_oe != 4'hF) rst_ok = 0;
                end else if (k < hdr) begin
                    rx_cmd = {rx_cmd[6:0], io_out[0]};
                    if (io_oe != 4'b0001) oe_bad = 1;
                end else if (k < hdr + 6) begin
                    rx_addr = {rx_addr[19:0], io_out};
                    if (io_oe != 4'hF) oe_bad = 1;
                end else if (k < hdr + 8) begin
                    rx_mode = {rx_mode[3:0], io_out};
                    if (io_oe != 4'hF) oe_bad = 1;
                end else if (io_oe != 4'h0) begin
                    oe_bad = 1;
                end
                k++;
            end
            if (!cs_n && !sclk && prev_sclk && !exp_rst && k >= hdr + 8) begin
                d = k - (hdr + 8);
                nb = fmem(rx_addr + 24'(d / 2));
                io_in <= (d % 2 == 0) ? nb[7:4] : nb[3:0];
            end
            if (cs_n && !prev_cs) begin
                if (exp_rst) begin
                    chk(rst_ok && k == MRST_CLKS, "R8 exit sequence clocks", k, MRST_CLKS);
                    mcont = 0;
                end else begin
                    chk(hdr == exp_hdr, "R5 opcode presence", hdr, exp_hdr);
                    if (hdr == 8) chk(rx_cmd == 8'hE3, "R2 opcode", rx_cmd, 8'hE3);
                    chk(rx_addr == exp_addr, "R3 address", rx_addr, exp_addr);
                    chk(rx_mode == exp_mode, "R3 mode byte", rx_mode, exp_mode);
                    chk(k == hdr + 8 + 2 * exp_len, "R4 clock count", k, hdr + 8 + 2 * exp_len);
                    chk(!oe_bad, "R6 line enables", oe_bad, 0);
                    mcont = (rx_mode[5:4] == 2'b10);
                end
                seen = 1;
            end
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
    end

    // Scoreboard monitor: compare each accepted byte with the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) chk(out_valid && out_data == pend_data, "R9 held byte",
                          {out_valid, out_data}, {1'b1, pend_data});
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(0, "R4 unexpected byte", out_data, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(out_data == e, "R4 data byte", out_data, e);
                end
            end
            pend = out_valid && !out_ready;
            pend_data = out_data;
        end
    end

    task automatic send(input logic [23:0] a, input int len, input bit keep,
                        input bit mr, output bit err);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_len = LEN_W'(len); req_keep = keep; req_mreset = mr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        err = req_err;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
    endtask

    task automatic rd(input logic [23:0] a, input int len, input bit keep);
        bit err;
        exp_rst = 0; exp_hdr = tb_cont ? 0 : 8; exp_addr = a;
        exp_mode = keep ? 8'h20 : 8'h00; exp_len = len;
        for (int i = 0; i < len; i++) exp_q.push_back(fmem(a + 24'(i)));
        send(a, len, keep, 0, err);
        chk(!err, "R7 valid read accepted", err, 0);
        if (!err) chk(!req_ready, "R10 busy not ready", req_ready, 0);
        tb_cont = keep;
        wait_done();
    endtask

    task automatic bad(input logic [23:0] a, input int len, input string tag);
        bit err;
        int s0;
        s0 = starts;
        send(a, len, 1'b1, 0, err);
        chk(err, tag, err, 1);
        repeat (20) @(negedge clk);
        chk(starts == s0 && cs_n, "R7 no bus activity", starts - s0, 0);
    endtask

    task automatic mreset();
        bit err;
        exp_rst = 1;
        send(24'h0, 0, 1'b0, 1'b1, err);
        chk(!err, "R8 exit accepted", err, 0);
        wait_done();
        exp_rst = 0;
        tb_cont = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && io_oe == 4'h0, "R1 reset bus state", {cs_n, sclk, io_oe}, 6'b100000);
        chk(!out_valid && req_ready, "R10 ready after reset", {out_valid, req_ready}, 2'b01);

        rd(24'h000100, 4, 0);     // normal read, opcode sent
        rd(24'h001230, 3, 1);     // opcode sent, enter continuous
        rd(24'h0ABC40, 5, 1);     // opcode skipped, stay continuous
        rd(24'h000050, 2, 0);     // opcode skipped, leave continuous
        rd(24'h000060, 1, 0);     // opcode back

        bad(24'h000071, 2, "R7 misaligned rejected");
        bad(24'h000080, 0, "R7 zero length rejected");
        cfg_quad_en = 1'b0;
        bad(24'h000090, 2, "R7 quad disabled rejected");
        cfg_quad_en = 1'b1;

        rd(24'h100000, 2, 1);     // into continuous
        mreset();                 // R8 exit sequence
        rd(24'h200000, 3, 0);     // opcode must return after exit

        bp_mode = 1'b1;           // R9 backpressure
        rd(24'h345670, 16, 0);
        rd(24'hFFFFF0, 24, 1);    // wraps the address space
        rd(24'h0000A0, 6, 0);
        bp_mode = 1'b0;

        repeat (10) @(negedge clk);
        chk(!idle_bad, "R1 sclk low while deselected", idle_bad, 0);
        chk(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule